// File: doc/BRIEF.md
# Dual-Rail Minterm-Collecting Logic Gate

This block computes any two-input Boolean function on dual-rail data. Each logical signal travels on a pair of wires: the "true" rail is raised to send a 1, the "false" rail is raised to send a 0, and both rails low form the spacer, which carries no data. Data moves under a four-phase return-to-zero discipline. A valid code is presented, then every signal goes back to the spacer before the next valid code is sent.

Internally, a row of four Muller C-elements generates the input minterms. Each C-element takes one rail of each input. A C-element sets when all of its inputs are high, clears when all of its inputs are low, and otherwise keeps its value. OR trees then steer each minterm onto the output true rail or the output false rail. The 4-bit parameter `FUNC` selects which rail each minterm drives, indexed by `{a,b}`. For prototyping, the C-elements are modelled as state holders clocked by `clk` and cleared by an active-low reset. As a result, each output change is due one clock edge after the input change that causes it.

Top module: `dims_gate`

## Requirements
- R1: Encoding: rail pair {t,f} = 10 means logic 1, 01 means logic 0, 00 is the spacer, and 11 is illegal. An illegal code on either input is flagged by an assertion.
- R2: While `rst_n` is low, and after reset until valid data arrives, `y_t` and `y_f` are both 0.
- R3: One clock edge after both inputs carry valid codes, `y_t` equals `FUNC[{a,b}]` and `y_f` is its complement. Here `{a,b}` is the 2-bit index with `a` as the MSB.
- R4: One clock edge after both inputs are in the spacer, both output rails are 0.
- R5: While the output is in the spacer, a valid code on only one input leaves the output in the spacer.
- R6: Once the output is valid, it holds its value while only one input has returned to the spacer.
- R7: `y_t` and `y_f` are never high together.
- R8: All 16 values of `FUNC` give the truth table described in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that updates the C-element state holders |
| rst_n | input | 1 | Active-low asynchronous reset; clears every C-element |
| a_t | input | 1 | Input a, true rail |
| a_f | input | 1 | Input a, false rail |
| b_t | input | 1 | Input b, true rail |
| b_f | input | 1 | Input b, false rail |
| y_t | output | 1 | Result, true rail |
| y_f | output | 1 | Result, false rail |

## Verification
Every result is due exactly one rising edge after the input change that causes it. This covers a valid output, a return to the spacer, and the absence of any change for a partial input or a hold. The bench drives inputs on the falling edge and pushes the expected rail values into a queue at that moment. Its monitor pops the queue and compares 2 ns after the next rising edge, so each comparison falls in the single cycle where the new value must already be present. Sixteen instances, one for each value of `FUNC`, share the same stimulus, so every function is compared on every vector.

// File: rtl/dims_pkg.sv
package dims_pkg;
  localparam int unsigned N_VARS = 2;
  localparam int unsigned N_MT   = 1 << N_VARS;

  // Rail selected for variable j inside minterm m: 1 picks true rail.
  function automatic logic pick_true(input int unsigned m, input int unsigned j);
    return ((m >> j) & 1) != 0;
  endfunction

  // Truth-table lookup for a dual-rail function, index {a,b}.
  function automatic logic truth_lookup(input logic [N_MT-1:0] func,
                                        input logic [N_VARS-1:0] idx);
    return func[idx];
  endfunction
endpackage

// File: rtl/dims_celem.sv
module dims_celem #(
  parameter int unsigned N_IN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] in,
  output logic            q
);
  logic all_hi;
  logic all_lo;

  assign all_hi = &in;
  assign all_lo = ~|in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (all_hi) q <= 1'b1;
    else if (all_lo) q <= 1'b0;
  end

  // R3: coincidence of ones must set the holder on the next edge
  assert_set_on_coincidence_R3: assert property (@(posedge clk) disable iff (!rst_n)
    all_hi |=> q);
  // R4: all-zero inputs must clear the holder
  assert_clear_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    all_lo |=> !q);
  // R6: mixed inputs keep the stored value
  assert_hold_on_mixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_hi && !all_lo) |=> $stable(q));
endmodule

// File: rtl/dims_minterm_row.sv
module dims_minterm_row
  import dims_pkg::*;
#(
  parameter int unsigned NV = N_VARS,
  localparam int unsigned NM = 1 << NV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] v_t,
  input  logic [NV-1:0] v_f,
  output logic [NM-1:0] mt
);
  for (genvar m = 0; m < NM; m++) begin : g_mt
    logic [NV-1:0] rails;
    for (genvar j = 0; j < NV; j++) begin : g_var
      if (pick_true(m, j)) begin : g_t
        assign rails[j] = v_t[j];
      end else begin : g_f
        assign rails[j] = v_f[j];
      end
    end
    dims_celem #(.N_IN(NV)) u_c (
      .clk  (clk),
      .rst_n(rst_n),
      .in   (rails),
      .q    (mt[m])
    );
  end

  // R7: at most one minterm active under a legal protocol
  assert_single_minterm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mt));
endmodule

// File: rtl/dims_or_collect.sv
module dims_or_collect #(
  parameter int unsigned        NM   = 4,
  parameter logic [NM-1:0]      FUNC = '0
) (
  input  logic [NM-1:0] mt,
  output logic          rail_t,
  output logic          rail_f
);
  assign rail_t = |(mt & FUNC);
  assign rail_f = |(mt & ~FUNC);
endmodule

// File: rtl/dims_gate.sv
module dims_gate
  import dims_pkg::*;
#(
  parameter logic [3:0] FUNC = 4'b0110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_t,
  input  logic a_f,
  input  logic b_t,
  input  logic b_f,
  output logic y_t,
  output logic y_f
);
  logic [N_MT-1:0] mt_q;
  logic a_valid, b_valid, both_valid, both_spacer, out_spacer;
  logic exp_bit;

  assign a_valid     = a_t ^ a_f;
  assign b_valid     = b_t ^ b_f;
  assign both_valid  = a_valid && b_valid;
  assign both_spacer = !(a_t || a_f || b_t || b_f);
  assign exp_bit     = truth_lookup(FUNC, {a_t, b_t});

  // variable 1 is a (MSB of the index), variable 0 is b
  dims_minterm_row #(.NV(N_VARS)) u_row (
    .clk  (clk),
    .rst_n(rst_n),
    .v_t  ({a_t, b_t}),
    .v_f  ({a_f, b_f}),
    .mt   (mt_q)
  );

  dims_or_collect #(.NM(N_MT), .FUNC(FUNC)) u_or (
    .mt    (mt_q),
    .rail_t(y_t),
    .rail_f(y_f)
  );

  assign out_spacer = !y_t && !y_f;

  assert_legal_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_t && a_f));
  assert_legal_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_t && b_f));
  assert_truth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    both_valid |=> (y_t == $past(exp_bit)) && (y_f == !$past(exp_bit)));
  assert_spacer_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    both_spacer |=> out_spacer);
  assert_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_spacer && !both_valid) |=> out_spacer);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_spacer && !both_spacer) |=> $stable({y_t, y_f}));
  assert_rails_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(y_t && y_f));
endmodule

// File: tb/dims_gate_tb.sv
module dims_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_t = 1'b0, a_f = 1'b0, b_t = 1'b0, b_f = 1'b0;
  logic [15:0] o_t, o_f;

  always #4 clk = ~clk;  // 125 MHz

  for (genvar k = 0; k < 16; k++) begin : g_fn
    dims_gate #(.FUNC(4'(k))) dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
      .y_t(o_t[k]), .y_f(o_f[k])
    );
  end

  typedef struct {
    logic [15:0] et;
    logic [15:0] ef;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] last_t = '0, last_f = '0;
  bit done = 0;

  // function k, value of a and b: bit number 2*a+b of k
  function automatic logic model_out(int k, logic av, logic bv);
    int pos;
    pos = (av ? 2 : 0) + (bv ? 1 : 0);
    return ((k >> pos) % 2) == 1;
  endfunction

  task automatic compare(logic [15:0] et, logic [15:0] ef, string tag);
    for (int k = 0; k < 16; k++) begin
      n_vec++;
      if (o_t[k] !== et[k] || o_f[k] !== ef[k]) begin
        n_bad++;
        $display("FAIL %s func=%0d actual t/f=%b%b expected t/f=%b%b",
                 tag, k, o_t[k], o_f[k], et[k], ef[k]);
      end
    end
  endtask

  // kind: 0 = valid result expected, 1 = spacer expected, 2 = hold previous
  task automatic drive(logic [1:0] ca, logic [1:0] cb, int kind, string tag);
    exp_item_t it;
    @(negedge clk);
    {a_t, a_f} = ca;
    {b_t, b_f} = cb;
    it.tag = tag;
    if (kind == 0) begin
      for (int k = 0; k < 16; k++) begin
        it.et[k] = model_out(k, ca[1], cb[1]);
        it.ef[k] = !it.et[k];
      end
    end else if (kind == 1) begin
      it.et = '0;
      it.ef = '0;
    end else begin
      it.et = last_t;
      it.ef = last_f;
    end
    last_t = it.et;
    last_f = it.ef;
    sb_q.push_back(it);
  endtask

  // monitor: pops one item per cycle, 2 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        compare(it.et, it.ef, it.tag);
      end
    end
  end

  localparam logic [1:0] ONE = 2'b10, ZERO = 2'b01, SP = 2'b00;

  initial begin
    repeat (3) @(negedge clk);
    compare('0, '0, "R2 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare('0, '0, "R2 after reset");

    // R3 R4 R8: all four codes, each followed by a spacer
    for (int c = 0; c < 4; c++) begin
      logic [1:0] ca, cb;
      ca = c[1] ? ONE : ZERO;
      cb = c[0] ? ONE : ZERO;
      drive(ca, cb, 0, "R3 R8 R1 valid code");
      drive(SP, SP, 1, "R4 spacer return");
    end

    // R5: only a valid, then only b valid
    drive(ONE, SP, 1, "R5 a alone");
    drive(ONE, SP, 1, "R5 a alone held");
    drive(ONE, ZERO, 0, "R3 b arrives");
    drive(SP, SP, 1, "R4 spacer");
    drive(SP, ZERO, 1, "R5 b alone");
    drive(ZERO, ZERO, 0, "R3 a arrives");

    // R6: one input back to spacer keeps the result
    drive(SP, ZERO, 2, "R6 a released");
    drive(SP, ZERO, 2, "R6 a released held");
    drive(SP, SP, 1, "R4 spacer after hold");
    drive(ZERO, ONE, 0, "R3 valid");
    drive(ZERO, SP, 2, "R6 b released");
    drive(SP, SP, 1, "R4 spacer final");

    // R7 covered in every compare: expected pairs never 11
    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule